// File: doc/BRIEF.md
# Volt-Second Imbalance Integrator

This block tracks how far a transformer core drifts toward DC bias. Two pulse inputs each stay high for the duration of one half-wave of the bridge output, positive or negative. A 16-bit word from an external converter carries the rectified voltage amplitude.

For each half-wave the block counts how many clock cycles the pulse stays high. It also captures the largest amplitude word seen during that time. Counting and capture run side by side, one unit per polarity. Once both polarities have been measured, the block forms the signed imbalance: positive amplitude times positive width, minus negative amplitude times negative width. It adds that imbalance to a saturating signed integral.

A control loop reads the sign and size of the integral and trims the half-wave duty cycles in opposite directions. The reset input is expected to be released already synchronised to `clk`.

Top module: `vsi_integrator`

## Requirements
- R1: Each pulse input passes through a two-flop synchroniser. A single-cycle pulse is still measured, with width 1. The result appears three clock edges after the falling input is sampled, one of those edges being the registration of the result.
- R2: A half-wave width equals the number of cycles the synchronised pulse is high. It is latched when the pulse falls.
- R3: The width count saturates at 2^CNT_W-1, which is 4095 by default, and never wraps.
- R4: A half-wave amplitude is the maximum ADC word sampled while the synchronised pulse is high. The running maximum restarts at every rising edge, so an earlier, larger pulse does not leak into a later one.
- R5: When both polarities hold a fresh measurement, err_o becomes Apos*Wpos - Aneg*Wneg as a signed value. This holds whichever polarity finished first.
- R6: In the same cycle, integral_o takes the previous integral plus err_o, and valid_o is high for exactly that one cycle. Without a completion or a clear, integral_o holds its value.
- R7: integral_o saturates at +(2^(INT_W-1)-1) and -(2^(INT_W-1)) instead of wrapping.
- R8: clear_i sets integral_o to zero at the next edge. If a completion falls on the same edge, integral_o becomes that period's err_o, and valid_o still pulses.
- R9: After reset, err_o and integral_o are zero and valid_o is low.
- R10: If a polarity completes twice before the other polarity completes, the later measurement replaces the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_pulse_i | input | 1 | High during the positive half-wave |
| neg_pulse_i | input | 1 | High during the negative half-wave |
| adc_i | input | AMP_W | Rectified amplitude sample |
| clear_i | input | 1 | Synchronous clear of the integral |
| err_o | output | AMP_W+CNT_W+1 | Signed per-period imbalance |
| integral_o | output | INT_W | Signed saturating running integral |
| valid_o | output | 1 | One-cycle strobe for new err_o and integral_o |

## Verification
The collision of interest is a software clear landing on the same edge as a period completion. Whichever of the two acts last would otherwise decide the result. The bench counts edges from the falling negative pulse so that clear_i is sampled on exactly the completion edge. It then expects integral_o to equal the fresh err_o rather than zero, and expects valid_o to pulse. A separate clear, away from any completion, must give zero with no strobe.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  localparam int unsigned VSI_AMP_W = 16;
  localparam int unsigned VSI_CNT_W = 12;
  localparam int unsigned VSI_INT_W = 40;

  typedef enum logic {
    HALF_POS = 1'b0,
    HALF_NEG = 1'b1
  } half_e;

  localparam int unsigned VSI_HALVES = 2;
endpackage

// File: rtl/vsi_edge_sync.sv
module vsi_edge_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/vsi_half_meter.sv
module vsi_half_meter #(
  parameter int unsigned AMP_W = 16,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [AMP_W-1:0] adc_i,
  output logic [CNT_W-1:0] width_o,
  output logic [AMP_W-1:0] amp_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, width_q, width_d;
  logic [AMP_W-1:0] peak_q, peak_d, amp_q, amp_d;
  logic             run_en, latch_en;

  assign run_en   = rise_i | level_i;
  assign latch_en = fall_i;

  always_comb begin
    cnt_d   = cnt_q;
    peak_d  = peak_q;
    width_d = width_q;
    amp_d   = amp_q;
    if (rise_i) begin
      cnt_d  = CNT_ONE;
      peak_d = adc_i;
    end else if (level_i) begin
      cnt_d  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
      peak_d = (adc_i > peak_q) ? adc_i : peak_q;
    end
    if (fall_i) begin
      width_d = cnt_q;
      amp_d   = peak_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      peak_q <= '0;
    end else if (run_en) begin
      cnt_q  <= cnt_d;
      peak_q <= peak_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      amp_q   <= '0;
    end else if (latch_en) begin
      width_q <= width_d;
      amp_q   <= amp_d;
    end
  end

  assign width_o = width_q;
  assign amp_o   = amp_q;
endmodule

// File: rtl/vsi_accum.sv
module vsi_accum #(
  parameter int unsigned AMP_W = 16,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned INT_W = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    fin_i,
  input  logic [1:0][CNT_W-1:0]         width_i,
  input  logic [1:0][AMP_W-1:0]         amp_i,
  input  logic                          clear_i,
  output logic signed [AMP_W+CNT_W:0]   err_o,
  output logic signed [INT_W-1:0]       integral_o,
  output logic                          valid_o
);
  import vsi_pkg::*;
  localparam int unsigned PROD_W = AMP_W + CNT_W;
  localparam int unsigned ERR_W  = PROD_W + 1;
  localparam int unsigned SUM_W  = INT_W + 1;
  localparam logic signed [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic [1:0]               done_q, done_d;
  logic                     take;
  logic [PROD_W-1:0]        prod_p, prod_n;
  logic signed [ERR_W-1:0]  err_d, err_q;
  logic signed [INT_W-1:0]  base, int_d, int_q;
  logic signed [SUM_W-1:0]  sum;
  logic                     valid_d, int_en;

  assign take   = &done_q;
  assign done_d = fin_i | (take ? 2'b00 : done_q);

  assign prod_p = PROD_W'(amp_i[HALF_POS]) * PROD_W'(width_i[HALF_POS]);
  assign prod_n = PROD_W'(amp_i[HALF_NEG]) * PROD_W'(width_i[HALF_NEG]);
  assign err_d  = $signed({1'b0, prod_p}) - $signed({1'b0, prod_n});

  assign base = clear_i ? '0 : int_q;
  assign sum  = {base[INT_W-1], base} + {{(SUM_W-ERR_W){err_d[ERR_W-1]}}, err_d};

  always_comb begin
    int_d = int_q;
    if (take) begin
      if (sum[SUM_W-1] != sum[SUM_W-2]) int_d = sum[SUM_W-1] ? INT_MIN : INT_MAX;
      else                               int_d = sum[INT_W-1:0];
    end else if (clear_i) begin
      int_d = '0;
    end
  end

  assign valid_d = take;
  assign int_en  = take | clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      valid_o <= 1'b0;
    end else begin
      done_q  <= done_d;
      valid_o <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= '0;
    else if (take)  err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       int_q <= '0;
    else if (int_en)  int_q <= int_d;
  end

  assign err_o      = err_q;
  assign integral_o = int_q;
endmodule

// File: rtl/vsi_integrator.sv
module vsi_integrator #(
  parameter int unsigned AMP_W = vsi_pkg::VSI_AMP_W,
  parameter int unsigned CNT_W = vsi_pkg::VSI_CNT_W,
  parameter int unsigned INT_W = vsi_pkg::VSI_INT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pos_pulse_i,
  input  logic                        neg_pulse_i,
  input  logic [AMP_W-1:0]            adc_i,
  input  logic                        clear_i,
  output logic signed [AMP_W+CNT_W:0] err_o,
  output logic signed [INT_W-1:0]     integral_o,
  output logic                        valid_o
);
  import vsi_pkg::*;
  localparam int unsigned NH = VSI_HALVES;

  logic [NH-1:0]            lvl, rise, fall;
  logic [NH-1:0][CNT_W-1:0] width;
  logic [NH-1:0][AMP_W-1:0] amp;

  vsi_edge_sync #(.N(NH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({neg_pulse_i, pos_pulse_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  for (genvar h = 0; h < NH; h++) begin : g_half
    vsi_half_meter #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (lvl[h]),
      .rise_i  (rise[h]),
      .fall_i  (fall[h]),
      .adc_i   (adc_i),
      .width_o (width[h]),
      .amp_o   (amp[h])
    );
  end

  vsi_accum #(.AMP_W(AMP_W), .CNT_W(CNT_W), .INT_W(INT_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin_i      (fall),
    .width_i    (width),
    .amp_i      (amp),
    .clear_i    (clear_i),
    .err_o      (err_o),
    .integral_o (integral_o),
    .valid_o    (valid_o)
  );
endmodule

module vsi_integrator_chk #(
  parameter int unsigned AMP_W = 16,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned INT_W = 40
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        clear_i,
  input logic signed [AMP_W+CNT_W:0] err_o,
  input logic signed [INT_W-1:0]     integral_o,
  input logic                        valid_o
);
  localparam logic signed [AMP_W+CNT_W:0] ERR_LIM =
    $signed({1'b0, {(AMP_W+CNT_W){1'b1}}});

  // R6: no completion and no clear means the integral holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (valid_o || $stable(integral_o)));

  // R6/R7: a positive error never lowers the integral
  a_r6_up: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (!valid_o || err_o <= 0 || integral_o >= $past(integral_o)));

  // R6/R7: a negative error never raises the integral
  a_r6_down: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (!valid_o || err_o >= 0 || integral_o <= $past(integral_o)));

  // R8: clear yields zero, or the fresh error when a completion coincides
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (valid_o ? (integral_o == err_o) : (integral_o == '0)));

  // R5: the error magnitude stays within one product
  a_r5_err_range: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o <= ERR_LIM) && (err_o >= -ERR_LIM));
endmodule

bind vsi_integrator vsi_integrator_chk #(.AMP_W(AMP_W), .CNT_W(CNT_W), .INT_W(INT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_i    (clear_i),
  .err_o      (err_o),
  .integral_o (integral_o),
  .valid_o    (valid_o)
);

// File: tb/vsi_integrator_tb.sv
module vsi_integrator_tb_top;
  localparam int AMP_W = 16;
  localparam int CNT_W = 12;
  localparam int INT_W = 30;
  localparam longint CMAX = (64'sd1 <<< CNT_W) - 1;
  localparam longint IMAX = (64'sd1 <<< (INT_W-1)) - 1;
  localparam longint IMIN = -(64'sd1 <<< (INT_W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos_pulse = 1'b0, neg_pulse = 1'b0, clr = 1'b0;
  logic [AMP_W-1:0] adc = '0;
  logic signed [AMP_W+CNT_W:0] err_o;
  logic signed [INT_W-1:0] integral_o;
  logic valid_o;

  always #4 clk = ~clk;

  vsi_integrator #(.AMP_W(AMP_W), .CNT_W(CNT_W), .INT_W(INT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pos_pulse_i(pos_pulse), .neg_pulse_i(neg_pulse),
    .adc_i(adc), .clear_i(clr), .err_o(err_o), .integral_o(integral_o), .valid_o(valid_o));

  int n_vec = 0, n_bad = 0, cycles = 0, n_valid = 0;
  string tag = "R9";
  longint last_err = 0, last_int = 0;

  // behavioural reference
  logic [1:0] hq[$];
  longint m_cnt[2], m_mx[2], m_w[2], m_a[2], m_err, m_int;
  bit m_done[2], m_val;

  function automatic longint sat(longint v);
    if (v > IMAX) return IMAX;
    if (v < IMIN) return IMIN;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq.delete();
      for (int h = 0; h < 2; h++) begin
        m_cnt[h] = 0; m_mx[h] = 0; m_w[h] = 0; m_a[h] = 0; m_done[h] = 0;
      end
      m_err = 0; m_int = 0; m_val = 0;
    end else begin
      bit lv, pv;
      hq.push_front({neg_pulse, pos_pulse});
      if (hq.size() > 4) void'(hq.pop_back());
      if (m_done[0] && m_done[1]) begin
        m_err = m_a[0]*m_w[0] - m_a[1]*m_w[1];
        m_int = sat((clr ? 0 : m_int) + m_err);
        m_val = 1; m_done[0] = 0; m_done[1] = 0;
      end else begin
        m_val = 0;
        if (clr) m_int = 0;
      end
      for (int h = 0; h < 2; h++) begin
        lv = (hq.size() > 2) ? hq[2][h] : 1'b0;
        pv = (hq.size() > 3) ? hq[3][h] : 1'b0;
        if (!lv && pv) begin m_w[h] = m_cnt[h]; m_a[h] = m_mx[h]; m_done[h] = 1; end
        if (lv && !pv) begin m_cnt[h] = 1; m_mx[h] = adc; end
        else if (lv) begin
          if (m_cnt[h] < CMAX) m_cnt[h]++;
          if (adc > m_mx[h]) m_mx[h] = adc;
        end
      end
    end
  end

  task automatic check(string req, longint act, longint exp, string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if (err_o != m_err || integral_o != m_int || valid_o != m_val) begin
        n_bad++;
        $display("FAIL %s cycle %0d actual err=%0d int=%0d v=%0b expected err=%0d int=%0d v=%0b",
                 tag, cycles, err_o, integral_o, valid_o, m_err, m_int, m_val);
      end
      if (valid_o) begin n_valid++; last_err = err_o; last_int = integral_o; end
    end
  end

  task automatic half(bit neg, int len, int peak, bit clr_hit);
    for (int i = 0; i < len + 6; i++) begin
      @(negedge clk);
      if (neg) neg_pulse = (i < len); else pos_pulse = (i < len);
      adc = AMP_W'((i == len/2 + 2) ? peak : (peak/2 + i % 5));
      clr = clr_hit && (i == len + 3);
    end
  endtask

  task automatic period(string req, int pl, int pp, int nl, int np);
    int v0 = n_valid;
    longint wp = (pl > CMAX) ? CMAX : pl;
    longint wn = (nl > CMAX) ? CMAX : nl;
    tag = req;
    half(0, pl, pp, 0);
    half(1, nl, np, 0);
    check(req, n_valid - v0, 1, "valid count");
    check(req, last_err, pp*wp - np*wn, "err");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", err_o, 0, "reset err");
    check("R9", integral_o, 0, "reset integral");
    check("R9", valid_o, 0, "reset valid");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    period("R2", 10, 1000, 10, 1000);
    check("R6", last_int, 0, "integral after balanced");
    period("R1", 1, 300, 3, 200);
    period("R4", 40, 5000, 20, 9000);
    period("R4", 30, 800, 25, 700);
    // R5: negative half completes first
    tag = "R5";
    half(1, 12, 400, 0);
    half(0, 15, 600, 0);
    check("R5", last_err, 600*15 - 400*12, "err neg-first");
    // R10: second positive pulse replaces the first
    tag = "R10";
    half(0, 50, 9000, 0);
    half(0, 20, 100, 0);
    half(1, 10, 100, 0);
    check("R10", last_err, 100*20 - 100*10, "err latest pos");
    period("R3", 4200, 200, 100, 200);
    for (int k = 0; k < 3; k++) period("R7", 4200, 65535, 2, 20);
    check("R7", last_int, IMAX, "positive saturation");
    for (int k = 0; k < 5; k++) period("R7", 2, 20, 4200, 65535);
    check("R7", last_int, IMIN, "negative saturation");
    // R8: isolated clear
    tag = "R8";
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R8", integral_o, 0, "clear alone");
    check("R8", valid_o, 0, "no strobe on clear");
    // R8: clear on the completion edge
    half(0, 30, 500, 0);
    half(1, 10, 300, 1);
    check("R8", last_int, 500*30 - 300*10, "clear with completion");
    repeat (5) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule